// File: doc/BRIEF.md
# Four-Channel DMA Arbiter and Register File

This block is the control core of a four-channel direct memory access engine. Peripherals raise active-high requests, and the block chooses one enabled requester under fixed or rotating priority. It pulls that channel's active-low acknowledge and presents the channel's current memory address and cycle type until a `xferDone` pulse comes back from the bus-cycle sequencer. Each completed cycle advances the channel address by one and lowers its cycle count by one. During the last programmed cycle, a terminal-count output is raised.

A CPU programs the block through an 8-bit register port. Each channel has a 16-bit address register and a 16-bit count register. In the count register, bits 13:0 hold N-1 for N cycles, and bits 15:14 hold the cycle type (0 verify, 1 write, 2 read, 3 illegal). A 16-bit register is accessed as two byte accesses, low byte first, which a shared byte-order toggle tracks. The port also reaches a mode register and a status register.

Register offsets (`regAddr`): 4'b0cc0 is the address register of channel cc, 4'b0cc1 is the count register of channel cc, 4'h8 is the mode register, and 4'h9 is the status register (read only). Mode bits: [3:0] enable channels 0..3, [4] selects rotating priority, [6] disables a channel automatically when it reaches terminal count, and [5] and [7] are stored with no effect. Status bits: [3:0] are the terminal-count flags of channels 0..3, [4] is the update flag, and [7:5] read as 0.

Top module: `dma_core`

## Requirements
- R1: After reset, all `chAckN` bits are 1, `tcOut` is 0, the mode register reads 0x00 and the status register reads 0x00.
- R2: A channel register access, read or write, uses the low byte first and then the high byte, toggling after each access. A write to the mode register returns the toggle to low byte.
- R3: A request from a channel whose mode enable bit is 0 is never acknowledged.
- R4: With mode bit 4 clear, the lowest-numbered enabled requesting channel is served.
- R5: With mode bit 4 set, the search starts at the channel after the one served last, so the channel just served has the lowest priority.
- R6: At most one `chAckN` bit is low. It goes low in the cycle after the grant and returns high after the clock edge at which `xferDone` is sampled high.
- R7: While a channel is served, `memAddr` shows its address register. Each completed cycle adds 1 to the address and subtracts 1 from count bits 13:0.
- R8: `tcOut` is 1 only while a channel is served and its count bits 13:0 are zero, which is its final cycle.
- R9: Completing a final cycle sets that channel's status bit. The bit stays set until a status read, which returns it as 1 and then clears it.
- R10: A high-byte write to the count register of an enabled channel sets the update flag (status bit 4). A status read leaves the flag as it is, and a mode write clears it.
- R11: With mode bit 6 set, completing a channel's final cycle clears that channel's enable bit in the mode register.
- R12: While a channel is served, `cycleType` equals its count bits 15:14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (advances toggle, clears status) |
| regAddr | input | 4 | Register offset |
| wrData | input | 8 | Write data byte |
| rdData | output | 8 | Read data byte (combinational) |
| chReq | input | 4 | Channel requests, active high |
| chAckN | output | 4 | Channel acknowledges, active low |
| xferDone | input | 1 | Current transfer cycle complete |
| memAddr | output | 16 | Address of the served channel, 0 when idle |
| cycleType | output | 2 | Cycle type of the served channel, 0 when idle |
| tcOut | output | 1 | Final cycle of the served channel |

## Verification
The bench runs one sequence of requests through both priority modes, with the rotation pointer carried from grant to grant. A design that rotated in fixed mode, or skipped the served channel wrongly, would acknowledge the wrong channel. It drives a two-cycle channel into terminal count and checks that `tcOut` rises only on the second cycle. It also checks that the status bit survives idle cycles and clears only after a read, which catches off-by-one counters and status bits that do not stick or never clear. The update flag is read twice and then after a mode write, which catches a flag cleared by the read. Auto-disable is observed through the mode register and a request that is then ignored.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int NCH      = 4;
  localparam int CH_W     = $clog2(NCH);
  localparam int ADDR_W   = 16;
  localparam int CNT_W    = 14;
  localparam int REG_W    = 16;
  localparam logic [3:0] MODE_OFS = 4'h8;
  localparam logic [3:0] STAT_OFS = 4'h9;
  localparam int ROT_BIT  = 4;
  localparam int STOP_BIT = 6;

  typedef struct packed {
    logic            serving;
    logic            step;
    logic [CH_W-1:0] ch;
  } dmaStrobe_t;
endpackage

// File: rtl/dma_ctrl.sv
module dma_ctrl
  import dma_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic [NCH-1:0] chReq,
  input  logic [NCH-1:0] enMask,
  input  logic           rotate,
  input  logic           xferDone,
  output dmaStrobe_t     strobe,
  output logic [NCH-1:0] chAckN
);
  logic            serving;
  logic [CH_W-1:0] activeCh;
  logic [CH_W-1:0] prioBase;
  logic            found;
  logic [CH_W-1:0] winner;

  always_comb begin
    logic [CH_W-1:0] base;
    logic [CH_W-1:0] idx;
    found  = 1'b0;
    winner = '0;
    base   = rotate ? prioBase : '0;
    for (int i = 0; i < NCH; i++) begin
      idx = base + CH_W'(i);
      if (!found && chReq[idx] && enMask[idx]) begin
        found  = 1'b1;
        winner = idx;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      serving  <= 1'b0;
      activeCh <= '0;
      prioBase <= '0;
    end else if (!serving) begin
      if (found) begin
        serving  <= 1'b1;
        activeCh <= winner;
      end
    end else if (xferDone) begin
      serving  <= 1'b0;
      prioBase <= activeCh + 1'b1;
    end
  end

  assign strobe.serving = serving;
  assign strobe.step    = serving && xferDone;
  assign strobe.ch      = activeCh;

  for (genvar g = 0; g < NCH; g++) begin : g_ack
    assign chAckN[g] = !(serving && (activeCh == CH_W'(g)));
  end
endmodule

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [3:0]        regAddr,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  input  dmaStrobe_t        strobe,
  output logic [NCH-1:0]    enMask,
  output logic              rotate,
  output logic [ADDR_W-1:0] memAddr,
  output logic [1:0]        cycleType,
  output logic              tcOut,
  output logic [NCH-1:0]    tcStat,
  output logic              updFlag
);
  logic [ADDR_W-1:0] addrR [NCH];
  logic [REG_W-1:0]  cntR  [NCH];
  logic [7:0]        modeR;
  logic [NCH-1:0]    tcR;
  logic              updR;
  logic              hiByte;

  logic            chSel;
  logic [CH_W-1:0] chIdx;
  logic            isCnt;
  logic            statRd;
  logic            stepZero;

  assign chSel    = !regAddr[3];
  assign chIdx    = regAddr[CH_W:1];
  assign isCnt    = regAddr[0];
  assign statRd   = regRd && (regAddr == STAT_OFS);
  assign stepZero = strobe.step && (cntR[strobe.ch][CNT_W-1:0] == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NCH; i++) begin
        addrR[i] <= '0;
        cntR[i]  <= '0;
      end
      modeR  <= '0;
      tcR    <= '0;
      updR   <= 1'b0;
      hiByte <= 1'b0;
    end else begin
      // transfer step first; CPU writes below take precedence
      if (strobe.step) begin
        addrR[strobe.ch] <= addrR[strobe.ch] + 1'b1;
        cntR[strobe.ch][CNT_W-1:0] <= cntR[strobe.ch][CNT_W-1:0] - 1'b1;
      end
      if (statRd) tcR <= '0;
      if (stepZero) begin
        tcR[strobe.ch] <= 1'b1;
        if (modeR[STOP_BIT]) modeR[strobe.ch] <= 1'b0;
      end
      if (regWr && regAddr == MODE_OFS) begin
        modeR  <= wrData;
        hiByte <= 1'b0;
        updR   <= 1'b0;
      end else if ((regWr || regRd) && chSel) begin
        hiByte <= !hiByte;
      end
      if (regWr && chSel) begin
        if (isCnt) begin
          if (hiByte) begin
            cntR[chIdx][15:8] <= wrData;
            if (modeR[chIdx]) updR <= 1'b1;
          end else begin
            cntR[chIdx][7:0] <= wrData;
          end
        end else begin
          if (hiByte) addrR[chIdx][15:8] <= wrData;
          else        addrR[chIdx][7:0]  <= wrData;
        end
      end
    end
  end

  always_comb begin
    logic [REG_W-1:0] sel;
    sel    = isCnt ? cntR[chIdx] : addrR[chIdx];
    rdData = '0;
    if (chSel)                      rdData = hiByte ? sel[15:8] : sel[7:0];
    else if (regAddr == MODE_OFS)   rdData = modeR;
    else if (regAddr == STAT_OFS)   rdData = {3'b000, updR, tcR};
  end

  assign enMask    = modeR[NCH-1:0];
  assign rotate    = modeR[ROT_BIT];
  assign memAddr   = strobe.serving ? addrR[strobe.ch] : '0;
  assign cycleType = strobe.serving ? cntR[strobe.ch][REG_W-1:CNT_W] : 2'b00;
  assign tcOut     = strobe.serving && (cntR[strobe.ch][CNT_W-1:0] == '0);
  assign tcStat    = tcR;
  assign updFlag   = updR;
endmodule

// File: rtl/dma_core.sv
module dma_core
  import dma_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [3:0]        regAddr,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  input  logic [NCH-1:0]    chReq,
  output logic [NCH-1:0]    chAckN,
  input  logic              xferDone,
  output logic [ADDR_W-1:0] memAddr,
  output logic [1:0]        cycleType,
  output logic              tcOut
);
  dmaStrobe_t     strobe;
  logic [NCH-1:0] enMask;
  logic           rotate;
  logic [NCH-1:0] tcStat;
  logic           updFlag;

  dma_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .chReq(chReq), .enMask(enMask),
    .rotate(rotate), .xferDone(xferDone), .strobe(strobe), .chAckN(chAckN)
  );

  dma_regs u_regs (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .wrData(wrData), .rdData(rdData), .strobe(strobe), .enMask(enMask),
    .rotate(rotate), .memAddr(memAddr), .cycleType(cycleType), .tcOut(tcOut),
    .tcStat(tcStat), .updFlag(updFlag)
  );
endmodule

// File: rtl/dma_core_chk.sv
module dma_core_chk
  import dma_pkg::*;
(
  input logic           clk,
  input logic           rstN,
  input logic           regWr,
  input logic           regRd,
  input logic [3:0]     regAddr,
  input logic [NCH-1:0] chAckN,
  input logic           xferDone,
  input logic           tcOut,
  input logic [NCH-1:0] tcStat,
  input logic           updFlag
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) !rstN |=> chAckN == '1);

  // R6
  ack_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~chAckN));

  // R6
  ack_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (chAckN != '1 && xferDone) |=> chAckN == '1);

  // R8
  tc_when_served_chk: assert property (@(posedge clk) disable iff (!rstN)
    tcOut |-> chAckN != '1);

  // R9
  tc_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(regRd && regAddr == STAT_OFS) |=> (tcStat & $past(tcStat)) == $past(tcStat));

  // R10
  upd_read_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regRd && regAddr == STAT_OFS && !regWr) |=> updFlag == $past(updFlag));
endmodule

bind dma_core dma_core_chk u_chk (
  .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
  .chAckN(chAckN), .xferDone(xferDone), .tcOut(tcOut),
  .tcStat(tcStat), .updFlag(updFlag)
);

// File: tb/dma_core_bench.sv
`timescale 1ns/1ps
module dma_core_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0, regRd = 1'b0, xferDone = 1'b0;
  logic [3:0]  regAddr = '0, chReq = '0;
  logic [7:0]  wrData = '0;
  logic [7:0]  rdData;
  logic [3:0]  chAckN;
  logic [15:0] memAddr;
  logic [1:0]  cycleType;
  logic        tcOut;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dma_core u_dma_core (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .wrData(wrData), .rdData(rdData), .chReq(chReq), .chAckN(chAckN),
    .xferDone(xferDone), .memAddr(memAddr), .cycleType(cycleType), .tcOut(tcOut)
  );

  // {rotate, request mask, expected chAckN}
  localparam logic [8:0] VECS [9] = '{
    {1'b0, 4'b1111, 4'b1110}, {1'b0, 4'b1110, 4'b1101},
    {1'b0, 4'b1100, 4'b1011}, {1'b0, 4'b1010, 4'b1101},
    {1'b1, 4'b1111, 4'b1011}, {1'b1, 4'b1111, 4'b0111},
    {1'b1, 4'b0110, 4'b1101}, {1'b1, 4'b0011, 4'b1110},
    {1'b1, 4'b0011, 4'b1101}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); regWr = 1'b1; regAddr = a; wrData = d;
    @(negedge clk); regWr = 1'b0;
  endtask

  task automatic rdReg(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); regRd = 1'b1; regAddr = a;
    #1 d = rdData;
    @(negedge clk); regRd = 1'b0;
  endtask

  task automatic wr16(input logic [3:0] a, input logic [15:0] v);
    wrReg(a, v[7:0]); wrReg(a, v[15:8]);
  endtask

  // grant then finish one transfer; returns ack seen while served
  task automatic xfer(input logic [3:0] req, output logic [3:0] ack);
    @(negedge clk); chReq = req;
    @(negedge clk); ack = chAckN;
    xferDone = 1'b1;
    @(negedge clk); xferDone = 1'b0; chReq = '0;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, d2;
    logic [3:0] ack;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    #1 chk(chAckN == 4'hF && tcOut == 1'b0, "R1 ack/tc", {chAckN, 3'b0, tcOut}, 16'hF0);
    rdReg(4'h8, d); chk(d == 8'h00, "R1 mode", d, 0);
    rdReg(4'h9, d); chk(d == 8'h00, "R1 status", d, 0);

    // R2 byte order and toggle reset by mode write
    wr16(4'h0, 16'h1234);
    rdReg(4'h0, d); rdReg(4'h0, d2);
    chk({d2, d} == 16'h1234, "R2 readback", {d2, d}, 16'h1234);
    wrReg(4'h0, 8'h77);
    wrReg(4'h8, 8'h00);
    wr16(4'h0, 16'hCDAB);
    rdReg(4'h0, d); rdReg(4'h0, d2);
    chk({d2, d} == 16'hCDAB, "R2 toggle reset", {d2, d}, 16'hCDAB);

    // program all channels: write type, 100 cycles
    for (int c = 0; c < 4; c++) begin
      wr16(4'(c * 2), 16'(c * 16'h1000));
      wr16(4'(c * 2 + 1), 16'h4063);
    end

    // R4 fixed then R5 rotating, table walk
    for (int v = 0; v < 9; v++) begin
      wrReg(4'h8, VECS[v][8] ? 8'h1F : 8'h0F);
      xfer(VECS[v][7:4], ack);
      chk(ack == VECS[v][3:0], VECS[v][8] ? "R5 rotate grant" : "R4 fixed grant",
          ack, VECS[v][3:0]);
    end

    // R3 disabled channel ignored
    wrReg(4'h8, 8'h02);
    @(negedge clk); chReq = 4'b0001;
    repeat (4) @(negedge clk);
    chk(chAckN == 4'hF, "R3 disabled ignored", chAckN, 4'hF);
    chReq = 4'b0011;
    @(negedge clk);
    chk(chAckN == 4'b1101, "R3 enabled served", chAckN, 4'b1101);
    xferDone = 1'b1; @(negedge clk); xferDone = 1'b0; chReq = '0;

    // R7 R8 R12 two read cycles on channel 2
    wrReg(4'h8, 8'h00);
    wr16(4'h4, 16'h2000);
    wr16(4'h5, 16'h8001);
    wrReg(4'h8, 8'h04);
    @(negedge clk); chReq = 4'b0100;
    @(negedge clk);
    chk(memAddr == 16'h2000, "R7 first address", memAddr, 16'h2000);
    chk(cycleType == 2'd2, "R12 cycle type", cycleType, 2);
    chk(tcOut == 1'b0, "R8 not final", tcOut, 0);
    xferDone = 1'b1; @(negedge clk); xferDone = 1'b0;
    @(negedge clk);
    chk(memAddr == 16'h2001, "R7 advanced address", memAddr, 16'h2001);
    chk(tcOut == 1'b1, "R8 final cycle", tcOut, 1);
    xferDone = 1'b1; @(negedge clk); xferDone = 1'b0; chReq = '0;
    #1 chk(tcOut == 1'b0, "R8 idle", tcOut, 0);
    repeat (3) @(negedge clk);
    // R9 sticky then cleared
    rdReg(4'h9, d); chk(d[3:0] == 4'b0100, "R9 tc set", d[3:0], 4'b0100);
    rdReg(4'h9, d); chk(d[3:0] == 4'b0000, "R9 tc cleared", d[3:0], 0);
    // R7 count readback: 0x8001 minus 2 wraps to 0xBFFF
    wrReg(4'h8, 8'h04);
    rdReg(4'h5, d); rdReg(4'h5, d2);
    chk({d2, d} == 16'hBFFF, "R7 count", {d2, d}, 16'hBFFF);

    // R10 update flag
    wr16(4'h5, 16'h4005);
    rdReg(4'h9, d); chk(d[4] == 1'b1, "R10 flag set", d[4], 1);
    rdReg(4'h9, d); chk(d[4] == 1'b1, "R10 kept by read", d[4], 1);
    wrReg(4'h8, 8'h00);
    rdReg(4'h9, d); chk(d[4] == 1'b0, "R10 mode clears", d[4], 0);

    // R11 auto-disable at terminal count
    wr16(4'h5, 16'h0000);
    wrReg(4'h8, 8'h44);
    xfer(4'b0100, ack);
    chk(ack == 4'b1011, "R11 served once", ack, 4'b1011);
    @(negedge clk); chReq = 4'b0100;
    repeat (3) @(negedge clk);
    chk(chAckN == 4'hF, "R11 no regrant", chAckN, 4'hF);
    chReq = '0;
    rdReg(4'h8, d); chk(d == 8'h40, "R11 enable cleared", d, 8'h40);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule